// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block tracks control flow for one wavefront of parallel lanes. It holds a stack in which every entry carries a program counter, a reconvergence PC and a lane mask. The entry on top supplies the PC the wavefront is executing, the PC at which its current path rejoins, and the set of lanes that are active.

A front end sends one command per cycle.
- A sequential step moves the PC forward by one instruction.
- An unconditional jump redirects the current path.
- A conditional split carries a target, the immediate post-dominator (supplied from outside) and one condition bit per lane.

On a split, the block retires the current entry. It then stacks a rejoin entry, a fall-through entry and a taken entry. It skips any entry that would be empty or redundant, so the taken path runs first. When a path reaches its reconvergence point, its entry is removed and the lanes merge back into the entry below.

Top module: `simt_reconv_stack`

## Requirements
- R1: While reset is asserted and after it is released, the stack holds exactly one entry: PC = `start_pc`, reconvergence PC = all ones (no reconvergence), mask = all ones, and `depth` = 1.
- R2: An unconditional jump (`cmd_op` = 2'b01) whose target equals the top reconvergence PC removes the top entry. Any other jump target replaces only the top PC and keeps its reconvergence PC and mask.
- R3: A conditional split (`cmd_op` = 2'b10) first removes the top entry. It then pushes (post-dominator, old reconvergence PC, old mask) only when the old reconvergence PC differs from the post-dominator.
- R4: A split next pushes the fall-through entry (old PC + 1, post-dominator, old mask AND NOT taken mask). It does so only when old PC + 1 differs from the post-dominator and at least one active lane is not taken. The taken mask is the condition vector AND the old mask.
- R5: A split pushes the taken entry (target, post-dominator, taken mask) last, so it ends on top. It does so only when the target differs from the post-dominator and the taken mask is non-zero. The target must never equal old PC + 1.
- R6: Command encoding: 2'b00 step, 2'b01 jump, 2'b10 split, 2'b11 no operation. With `cmd_valid` low, or with op 2'b11, the stack is unchanged.
- R7: A sequential step (`cmd_op` = 2'b00) adds one to the top PC. If the new PC equals the top reconvergence PC, the top entry is removed in the same cycle instead.
- R8: `cur_pc`, `cur_rpc` and `cur_mask` show the top entry, and `depth` shows the entry count. When the stack is empty, all three show zero.
- R9: A split that would leave more than DEPTH entries is rejected and leaves the stack unchanged. `overflow_err` is high for the one cycle after the rejected command.
- R10: A step, jump or split on an empty stack is rejected, and `underflow_err` is high for the one cycle after it. The two error flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pc | input | PC_W | PC loaded into the single entry at reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 step, 01 jump, 10 split, 11 none |
| tgt_pc | input | PC_W | Target of a jump or split |
| ipdom_pc | input | PC_W | Immediate post-dominator of a split |
| cond_lanes | input | LANES | Per-lane branch condition of a split |
| cur_pc | output | PC_W | PC of the top entry |
| cur_rpc | output | PC_W | Reconvergence PC of the top entry |
| cur_mask | output | LANES | Active lane mask of the top entry |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |
| overflow_err | output | 1 | Previous command rejected for lack of space |
| underflow_err | output | 1 | Previous command rejected on an empty stack |

## Verification
Nested if/else regions are driven with partial condition vectors, so all three pushes appear and the order of the taken and fall-through entries is checked. Condition vectors that cover every active lane or none of them separate the single-path cases from true divergence. A split whose target equals the post-dominator, and another whose fall-through equals it, check that each skip rule is tied to the right comparison. Repeated divergent splits fill the stack until it overflows, and jumps and steps on an emptied stack provoke underflow, while steps that walk onto a reconvergence PC check the merge pop.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
    typedef enum logic [1:0] {
        OP_STEP  = 2'b00,
        OP_JUMP  = 2'b01,
        OP_SPLIT = 2'b10,
        OP_IDLE  = 2'b11
    } flow_op_e;
endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split #(
    parameter int LANES = 16,
    parameter int PC_W  = 32
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  cur_rpc,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond_lanes,
    input  logic [PC_W-1:0]  tgt_pc,
    input  logic [PC_W-1:0]  ipdom_pc,
    output logic [LANES-1:0] tk_mask,
    output logic [LANES-1:0] nt_mask,
    output logic [PC_W-1:0]  nt_pc,
    output logic             join_en,
    output logic             nt_en,
    output logic             tk_en,
    output logic [1:0]       push_cnt
);
    always_comb begin
        tk_mask  = cond_lanes & cur_mask;
        nt_mask  = cur_mask & ~tk_mask;
        nt_pc    = cur_pc + PC_W'(1);
        join_en  = (cur_rpc != ipdom_pc);
        // fewer taken lanes than active lanes <=> some active lane not taken
        nt_en    = (nt_pc != ipdom_pc) && (|nt_mask);
        tk_en    = (tgt_pc != ipdom_pc) && (|tk_mask);
        push_cnt = {1'b0, join_en} + {1'b0, nt_en} + {1'b0, tk_en};
    end
endmodule

// File: rtl/simt_flow_step.sv
module simt_flow_step #(
    parameter int PC_W = 32
) (
    input  logic            is_jump,
    input  logic [PC_W-1:0] top_pc,
    input  logic [PC_W-1:0] top_rpc,
    input  logic [PC_W-1:0] tgt_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            pop_en
);
    always_comb begin
        next_pc = is_jump ? tgt_pc : (top_pc + PC_W'(1));
        pop_en  = (next_pc == top_rpc);
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_reconv_pkg::*;
#(
    parameter int LANES = 16,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [PC_W-1:0]  tgt_pc,
    input  logic [PC_W-1:0]  ipdom_pc,
    input  logic [LANES-1:0] cond_lanes,
    output logic [PC_W-1:0]  cur_pc,
    output logic [PC_W-1:0]  cur_rpc,
    output logic [LANES-1:0] cur_mask,
    output logic [CNT_W-1:0] depth,
    output logic             overflow_err,
    output logic             underflow_err
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  rpc;
        logic [LANES-1:0] mask;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ents;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             udf;
    } st_t;

    st_t st_q, st_d, st_rst;

    flow_op_e         op;
    logic             have_top;
    logic [IDX_W-1:0] top_idx;
    ent_t             top_e;

    logic [LANES-1:0] sp_tk_mask, sp_nt_mask;
    logic [PC_W-1:0]  sp_nt_pc;
    logic             sp_join, sp_nt, sp_tk;
    logic [1:0]       sp_cnt;
    logic [PC_W-1:0]  fs_next_pc;
    logic             fs_pop;

    always_comb begin
        op       = flow_op_e'(cmd_op);
        have_top = (st_q.cnt != '0);
        top_idx  = IDX_W'(st_q.cnt - CNT_W'(1));
        top_e    = have_top ? st_q.ents[top_idx] : '0;
    end

    simt_lane_split #(.LANES(LANES), .PC_W(PC_W)) u_split (
        .cur_pc     (top_e.pc),
        .cur_rpc    (top_e.rpc),
        .cur_mask   (top_e.mask),
        .cond_lanes (cond_lanes),
        .tgt_pc     (tgt_pc),
        .ipdom_pc   (ipdom_pc),
        .tk_mask    (sp_tk_mask),
        .nt_mask    (sp_nt_mask),
        .nt_pc      (sp_nt_pc),
        .join_en    (sp_join),
        .nt_en      (sp_nt),
        .tk_en      (sp_tk),
        .push_cnt   (sp_cnt)
    );

    simt_flow_step #(.PC_W(PC_W)) u_step (
        .is_jump (op == OP_JUMP),
        .top_pc  (top_e.pc),
        .top_rpc (top_e.rpc),
        .tgt_pc  (tgt_pc),
        .next_pc (fs_next_pc),
        .pop_en  (fs_pop)
    );

    always_comb begin
        st_rst             = '0;
        st_rst.cnt         = CNT_W'(1);
        st_rst.ents[0].pc  = start_pc;
        st_rst.ents[0].rpc = {PC_W{1'b1}};
        st_rst.ents[0].mask = {LANES{1'b1}};
    end

    always_comb begin
        int wp;
        wp       = 0;
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.udf = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_STEP, OP_JUMP: begin
                    if (!have_top)    st_d.udf = 1'b1;
                    else if (fs_pop)  st_d.cnt = st_q.cnt - CNT_W'(1);
                    else              st_d.ents[top_idx].pc = fs_next_pc;
                end
                OP_SPLIT: begin
                    if (!have_top) begin
                        st_d.udf = 1'b1;
                    end else if (int'(st_q.cnt) - 1 + int'(sp_cnt) > DEPTH) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        wp = int'(st_q.cnt) - 1;
                        if (sp_join) begin
                            st_d.ents[IDX_W'(wp)] = ent_t'{pc: ipdom_pc, rpc: top_e.rpc, mask: top_e.mask};
                            wp = wp + 1;
                        end
                        if (sp_nt) begin
                            st_d.ents[IDX_W'(wp)] = ent_t'{pc: sp_nt_pc, rpc: ipdom_pc, mask: sp_nt_mask};
                            wp = wp + 1;
                        end
                        if (sp_tk) begin
                            st_d.ents[IDX_W'(wp)] = ent_t'{pc: tgt_pc, rpc: ipdom_pc, mask: sp_tk_mask};
                            wp = wp + 1;
                        end
                        st_d.cnt = CNT_W'(wp);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign cur_pc        = top_e.pc;
    assign cur_rpc       = top_e.rpc;
    assign cur_mask      = top_e.mask;
    assign depth         = st_q.cnt;
    assign overflow_err  = st_q.ovf;
    assign underflow_err = st_q.udf;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH); // R9

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_err && underflow_err)); // R10

    AST_FALLTHRU_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SPLIT && have_top) |-> (tgt_pc != cur_pc + PC_W'(1))); // R5

    AST_JUMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_JUMP && have_top && tgt_pc != cur_rpc)
        |=> (cur_pc == $past(tgt_pc) && cur_rpc == $past(cur_rpc) && cur_mask == $past(cur_mask))); // R2

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_STEP && have_top && cur_pc + PC_W'(1) != cur_rpc)
        |=> (cur_pc == $past(cur_pc) + PC_W'(1) && depth == $past(depth))); // R7

    AST_TAKEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SPLIT && have_top && tgt_pc != ipdom_pc && (|(cond_lanes & cur_mask)))
        |=> (overflow_err || (cur_pc == $past(tgt_pc) && cur_mask == $past(cond_lanes & cur_mask)))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || op == OP_IDLE)
        |=> (depth == $past(depth) && cur_pc == $past(cur_pc) && cur_mask == $past(cur_mask))); // R6
endmodule

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;
    localparam int LANES = 16;
    localparam int PC_W  = 32;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [PC_W-1:0]  start_pc;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [PC_W-1:0]  tgt_pc, ipdom_pc;
    logic [LANES-1:0] cond_lanes;
    logic [PC_W-1:0]  cur_pc, cur_rpc;
    logic [LANES-1:0] cur_mask;
    logic [CNT_W-1:0] depth;
    logic             overflow_err, underflow_err;

    int n_vec = 0;
    int n_bad = 0;

    logic [PC_W-1:0]  q_pc[$];
    logic [PC_W-1:0]  q_rpc[$];
    logic [LANES-1:0] q_msk[$];
    logic             e_ovf, e_udf;

    always #10 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .tgt_pc(tgt_pc), .ipdom_pc(ipdom_pc), .cond_lanes(cond_lanes),
        .cur_pc(cur_pc), .cur_rpc(cur_rpc), .cur_mask(cur_mask), .depth(depth),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    function automatic logic [PC_W-1:0] top_pc();
        return (q_pc.size() > 0) ? q_pc[q_pc.size()-1] : '0;
    endfunction

    function automatic logic [LANES-1:0] top_msk();
        return (q_msk.size() > 0) ? q_msk[q_msk.size()-1] : '0;
    endfunction

    function automatic void pop_model();
        void'(q_pc.pop_back());
        void'(q_rpc.pop_back());
        void'(q_msk.pop_back());
    endfunction

    function automatic void push_model(logic [PC_W-1:0] p, logic [PC_W-1:0] r, logic [LANES-1:0] m);
        q_pc.push_back(p);
        q_rpc.push_back(r);
        q_msk.push_back(m);
    endfunction

    function automatic void model(logic v, logic [1:0] op, logic [PC_W-1:0] tgt,
                                  logic [PC_W-1:0] ipd, logic [LANES-1:0] cnd);
        int n;
        logic [PC_W-1:0]  pc, rpc, np;
        logic [LANES-1:0] m, tk, nt;
        int pushes;
        n = q_pc.size();
        e_ovf = 1'b0;
        e_udf = 1'b0;
        if (!v || op == 2'b11) return;
        if (n == 0) begin
            e_udf = 1'b1;
            return;
        end
        pc  = q_pc[n-1];
        rpc = q_rpc[n-1];
        m   = q_msk[n-1];
        if (op == 2'b00 || op == 2'b01) begin
            np = (op == 2'b01) ? tgt : pc + 1;
            if (np == rpc) pop_model();
            else q_pc[n-1] = np;
        end else begin
            tk = cnd & m;
            nt = m & ~tk;
            pushes = 0;
            if (rpc != ipd) pushes++;
            if (pc + 1 != ipd && nt != 0) pushes++;
            if (tgt != ipd && tk != 0) pushes++;
            if (n - 1 + pushes > DEPTH) begin
                e_ovf = 1'b1;
            end else begin
                pop_model();
                if (rpc != ipd) push_model(ipd, rpc, m);
                if (pc + 1 != ipd && nt != 0) push_model(pc + 1, ipd, nt);
                if (tgt != ipd && tk != 0) push_model(tgt, ipd, tk);
            end
        end
    endfunction

    task automatic compare(string req);
        int n;
        logic [PC_W-1:0]  x_pc, x_rpc;
        logic [LANES-1:0] x_m;
        logic bad;
        n = q_pc.size();
        x_pc  = (n > 0) ? q_pc[n-1] : '0;
        x_rpc = (n > 0) ? q_rpc[n-1] : '0;
        x_m   = (n > 0) ? q_msk[n-1] : '0;
        bad = 1'b0;
        n_vec++;
        if (cur_pc !== x_pc) begin
            $display("FAIL %s cur_pc actual %h expected %h", req, cur_pc, x_pc); bad = 1'b1;
        end
        if (cur_rpc !== x_rpc) begin
            $display("FAIL %s cur_rpc actual %h expected %h", req, cur_rpc, x_rpc); bad = 1'b1;
        end
        if (cur_mask !== x_m) begin
            $display("FAIL %s cur_mask actual %h expected %h", req, cur_mask, x_m); bad = 1'b1;
        end
        if (int'(depth) != n) begin
            $display("FAIL %s depth actual %0d expected %0d", req, depth, n); bad = 1'b1;
        end
        if (overflow_err !== e_ovf) begin
            $display("FAIL %s overflow_err actual %b expected %b", req, overflow_err, e_ovf); bad = 1'b1;
        end
        if (underflow_err !== e_udf) begin
            $display("FAIL %s underflow_err actual %b expected %b", req, underflow_err, e_udf); bad = 1'b1;
        end
        if (bad) n_bad++;
    endtask

    // inputs change at the falling edge; result is sampled at the next falling edge
    task automatic cmd(logic v, logic [1:0] op, logic [PC_W-1:0] tgt,
                       logic [PC_W-1:0] ipd, logic [LANES-1:0] cnd, string req);
        cmd_valid  = v;
        cmd_op     = op;
        tgt_pc     = tgt;
        ipdom_pc   = ipd;
        cond_lanes = cnd;
        model(v, op, tgt, ipd, cnd);
        @(negedge clk);
        cmd_valid = 1'b0;
        compare(req);
    endtask

    task automatic do_reset(logic [PC_W-1:0] sp);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_op = 2'b11;
        tgt_pc = '0;
        ipdom_pc = '0;
        cond_lanes = '0;
        start_pc = sp;
        q_pc.delete();
        q_rpc.delete();
        q_msk.delete();
        push_model(sp, '1, '1);
        e_ovf = 1'b0;
        e_udf = 1'b0;
        repeat (2) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
    endtask

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog expired, actual running expected finished");
        n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(32'h100);
        cmd(1'b1, 2'b00, '0, '0, '0, "R7 step");
        cmd(1'b1, 2'b00, '0, '0, '0, "R7 step");
        cmd(1'b0, 2'b01, 32'h500, '0, '0, "R6 valid low");
        cmd(1'b1, 2'b11, 32'h500, 32'h9, 16'hffff, "R6 op none");
        // outer if/else, half the lanes taken
        cmd(1'b1, 2'b10, 32'h110, 32'h120, 16'h00ff, "R3 R4 R5 outer split");
        // nested split inside the taken path
        cmd(1'b1, 2'b10, 32'h118, 32'h11c, 16'h000f, "R3 R4 R5 nested split");
        cmd(1'b1, 2'b01, 32'h11c, '0, '0, "R2 jump to rpc pops");
        for (int k = 0; k < 12 && top_pc() != 32'h11c; k++)
            cmd(1'b1, 2'b00, '0, '0, '0, "R7 step to rpc");
        cmd(1'b1, 2'b01, 32'h130, '0, '0, "R2 jump keeps rpc and mask");
        cmd(1'b1, 2'b01, 32'h120, '0, '0, "R2 jump to rpc pops");
        cmd(1'b1, 2'b10, 32'h108, 32'h120, 16'hffff, "R4 all lanes taken");
        cmd(1'b1, 2'b10, 32'h140, 32'h120, 16'h00ff, "R5 no lanes taken");
        cmd(1'b1, 2'b10, 32'h120, 32'h120, 16'h0f00, "R5 target equals ipdom");
        cmd(1'b1, 2'b10, 32'h100, 32'h10b, 16'h1000, "R4 fall-through equals ipdom");
        cmd(1'b1, 2'b00, '0, '0, '0, "R7 step");

        do_reset(32'h200);
        for (int k = 0; k < 4; k++) begin
            logic [LANES-1:0] m;
            m = top_msk();
            cmd(1'b1, 2'b10, top_pc() + 32'h40, 32'h800 + 32'(k * 4), m & (m - 1'b1), "R9 fill stack");
        end
        cmd(1'b1, 2'b00, '0, '0, '0, "R9 flag clears");

        do_reset(32'h300);
        cmd(1'b1, 2'b01, 32'hffff_ffff, '0, '0, "R2 R8 pop to empty");
        cmd(1'b1, 2'b00, '0, '0, '0, "R10 step on empty");
        cmd(1'b1, 2'b10, 32'h10, 32'h20, 16'hffff, "R10 split on empty");
        cmd(1'b1, 2'b01, 32'h10, '0, '0, "R10 jump on empty");
        cmd(1'b1, 2'b11, '0, '0, '0, "R10 flag clears");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule